// File: doc/BRIEF.md
# Analog Gamepad Nibble-Serial Responder

This block is the controller-side logic of an analog gamepad that sits behind a 7-bit parallel game port. The host steers the pad through masked writes. Bit 6 of the port is the select line. The pad answers each read with a 4-bit nibble. Each nibble comes from one of three sources: eight active-low buttons, two bidirectional stick axes (X and Y), or one unidirectional axis (Z). Each axis is 8 bits wide.

The responder does not count clock edges. It counts host accesses. Every read steps a 3-bit cycle field. Every write that is not a falling edge of the select line moves to the next acquisition sequence, but only when enough reads have happened since the last restart. A falling edge on the select line restarts acquisition. Each sequence spans eight reads: four return one nibble, and the next four return the following nibble. There are at most five sequences.

The axis values are held in registers that a sampling front end loads through a load strobe. The design is generated once per port. Each port keeps its own state.

Top module: `apad_responder`

## Requirements
- R1: After reset, each port's stored port state is 0x40 (select line high), and its cycle/sequence counter and read-latency counter are 0. The first read therefore returns 0x60 OR the first button nibble.
- R2: A write changes only the stored bits whose mask bit is 1: new = (old AND NOT mask) OR (data AND mask). If mask bit 6 is 0, the select line keeps its value.
- R3: A write that takes the stored select bit (bit 6) from 1 to 0 clears both the counter and the latency count. The next read returns nibble 0.
- R4: Any other write advances the sequence only when more than 2 reads have occurred since the last restart. Otherwise the counter is left unchanged.
- R5: An advancing write clears the low 3 counter bits and adds 8.
- R6: The counter saturates at 32 (a fifth sequence). Further advancing writes leave it at 32.
- R7: Each read increments the low 3 counter bits modulo 8, leaves the upper bits alone, and does not change the stored port state.
- R8: The nibble index is counter bits [5:2]. Index 0 is buttons[7:4] and index 1 is buttons[3:0]. Indices 2 to 7 are the high nibble then the low nibble of X, then Y, then Z. Indices 8 and 9 return 0.
- R9: Button inputs are active low and are inverted before they are placed in a nibble.
- R10: The read value has bit 6 = 1, bit 5 = stored select bit, bit 4 = counter bit 2, and bits 3:0 = the selected nibble.
- R11: The held axis registers reset to 128. A load strobe captures all three axis inputs of that port in one cycle.
- R12: Ports are independent. Accesses on one port never change what another port returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | NUM_PORTS | Single-cycle host write strobe per port |
| wr_data | input | 7*NUM_PORTS | Write data, 7 bits per port |
| wr_mask | input | 7*NUM_PORTS | Output-enable mask for the write, 7 bits per port |
| rd_stb | input | NUM_PORTS | Single-cycle host read strobe per port |
| rd_data | output | 7*NUM_PORTS | Read value per port, valid while the read strobe is high |
| btn_n | input | 8*NUM_PORTS | Active-low buttons per port |
| axis_ld | input | NUM_PORTS | Load strobe for the held axis registers |
| axis_x | input | 8*NUM_PORTS | Stick X sample per port |
| axis_y | input | 8*NUM_PORTS | Stick Y sample per port |
| axis_z | input | 8*NUM_PORTS | Unidirectional axis sample per port |

## Verification
The assertions assume that the host never raises a read strobe and a write strobe on the same port in the same cycle. They also assume that the buttons do not change in the cycle just after a restarting write. The bench drives each access as a separate one-cycle pulse from its own task, so these assumptions always hold. It changes buttons only while the port is idle. The stimulus covers full five-plus-one sequence sweeps on both ports with centred and loaded axes, early writes that the latency guard blocks, and masked writes that leave the select line alone.

// File: rtl/apad_pkg.sv
`timescale 1ns/1ps
package apad_pkg;
  localparam int PORT_W      = 7;
  localparam int TH_BIT      = 6;
  localparam int AXIS_W      = 8;
  localparam int BTN_W       = 8;
  localparam int NUM_AX      = 3;
  localparam int CYC_PER_SEQ = 8;
  localparam int CYC_W       = $clog2(CYC_PER_SEQ);
  localparam logic [AXIS_W-1:0] AXIS_CENTER = AXIS_W'(1) << (AXIS_W - 1);

  typedef logic [PORT_W-1:0] port_t;
  typedef logic [NUM_AX-1:0][AXIS_W-1:0] axes_t;

  localparam port_t STATE_RST = port_t'(1) << TH_BIT;

  function automatic int cnt_width(input int max_seq);
    return $clog2(max_seq * CYC_PER_SEQ);
  endfunction
endpackage

// File: rtl/apad_seq_ctrl.sv
`timescale 1ns/1ps
module apad_seq_ctrl
  import apad_pkg::*;
#(
  parameter int MAX_SEQ   = 5,
  parameter int LAT_GUARD = 2,
  parameter int CNT_W     = cnt_width(MAX_SEQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  port_t            wr_data,
  input  port_t            wr_mask,
  input  logic             rd_stb,
  output logic             th_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int CNT_MAX = (MAX_SEQ - 1) * CYC_PER_SEQ;
  localparam int LAT_SAT = LAT_GUARD + 1;
  localparam int LAT_W   = $clog2(LAT_SAT + 1);

  port_t             state_q, state_d, merged;
  logic [CNT_W-1:0]  cnt_d;
  logic [CNT_W:0]    next_seq;
  logic [LAT_W-1:0]  lat_q, lat_d;
  logic              th_fall, upd_en;

  assign merged   = (state_q & ~wr_mask) | (wr_data & wr_mask);
  assign th_fall  = state_q[TH_BIT] & ~merged[TH_BIT];
  assign next_seq = {1'b0, cnt_q[CNT_W-1:CYC_W], {CYC_W{1'b0}}} + (CNT_W+1)'(CYC_PER_SEQ);
  assign upd_en   = wr_stb | rd_stb;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lat_d   = lat_q;
    if (wr_stb) begin
      state_d = merged;
      if (th_fall) begin
        cnt_d = '0;
        lat_d = '0;
      end else if (lat_q > LAT_W'(LAT_GUARD)) begin
        if (next_seq > (CNT_W+1)'(CNT_MAX)) cnt_d = CNT_W'(CNT_MAX);
        else                                cnt_d = next_seq[CNT_W-1:0];
      end
    end else if (rd_stb) begin
      cnt_d = {cnt_q[CNT_W-1:CYC_W], cnt_q[CYC_W-1:0] + CYC_W'(1)};
      if (lat_q != LAT_W'(LAT_SAT)) lat_d = lat_q + LAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= STATE_RST;
      cnt_q   <= '0;
      lat_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lat_q   <= lat_d;
    end
  end

  assign th_q = state_q[TH_BIT];
endmodule

// File: rtl/apad_axis_hold.sv
`timescale 1ns/1ps
module apad_axis_hold
  import apad_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld,
  input  axes_t axes_in,
  output axes_t axes_q
);
  for (genvar a = 0; a < NUM_AX; a++) begin : g_axis
    logic [AXIS_W-1:0] val_d;
    assign val_d = axes_in[a];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  axes_q[a] <= AXIS_CENTER;
      else if (ld) axes_q[a] <= val_d;
    end
  end
endmodule

// File: rtl/apad_nibble_mux.sv
`timescale 1ns/1ps
module apad_nibble_mux
  import apad_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [BTN_W-1:0] btn_n,
  input  axes_t            axes,
  input  logic [IDX_W-1:0] idx,
  input  logic             th,
  output port_t            rd_data
);
  localparam int GRP_W = IDX_W - 1;

  logic [GRP_W-1:0]  grp;
  logic [AXIS_W-1:0] word;
  logic [3:0]        nib;

  assign grp = idx[IDX_W-1:1];

  always_comb begin
    word = '0;
    if (grp == '0) begin
      word = ~btn_n;
    end else begin
      for (int a = 0; a < NUM_AX; a++) begin
        if (grp == GRP_W'(a + 1)) word = axes[a];
      end
    end
  end

  assign nib     = idx[0] ? word[3:0] : word[AXIS_W-1:AXIS_W-4];
  assign rd_data = {1'b1, th, idx[0], nib};
endmodule

// File: rtl/apad_port.sv
`timescale 1ns/1ps
module apad_port
  import apad_pkg::*;
#(
  parameter int MAX_SEQ   = 5,
  parameter int LAT_GUARD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  port_t            wr_data,
  input  port_t            wr_mask,
  input  logic             rd_stb,
  output port_t            rd_data,
  input  logic [BTN_W-1:0] btn_n,
  input  logic             axis_ld,
  input  axes_t            axes_in
);
  localparam int CNT_W = cnt_width(MAX_SEQ);
  localparam int IDX_W = CNT_W - 2;

  logic             th;
  logic [CNT_W-1:0] cnt;
  axes_t            axes;

  apad_seq_ctrl #(.MAX_SEQ(MAX_SEQ), .LAT_GUARD(LAT_GUARD), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_stb(rd_stb), .th_q(th), .cnt_q(cnt)
  );

  apad_axis_hold u_axes (
    .clk(clk), .rst_n(rst_n), .ld(axis_ld), .axes_in(axes_in), .axes_q(axes)
  );

  apad_nibble_mux #(.IDX_W(IDX_W)) u_mux (
    .btn_n(btn_n), .axes(axes), .idx(cnt[CNT_W-1:2]), .th(th), .rd_data(rd_data)
  );
endmodule

// File: rtl/apad_responder.sv
`timescale 1ns/1ps
module apad_responder
  import apad_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int MAX_SEQ   = 5,
  parameter int LAT_GUARD = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          wr_stb,
  input  logic [NUM_PORTS*PORT_W-1:0]   wr_data,
  input  logic [NUM_PORTS*PORT_W-1:0]   wr_mask,
  input  logic [NUM_PORTS-1:0]          rd_stb,
  output logic [NUM_PORTS*PORT_W-1:0]   rd_data,
  input  logic [NUM_PORTS*BTN_W-1:0]    btn_n,
  input  logic [NUM_PORTS-1:0]          axis_ld,
  input  logic [NUM_PORTS*AXIS_W-1:0]   axis_x,
  input  logic [NUM_PORTS*AXIS_W-1:0]   axis_y,
  input  logic [NUM_PORTS*AXIS_W-1:0]   axis_z
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    axes_t axes_in;
    port_t rd_p;
    assign axes_in = {axis_z[p*AXIS_W +: AXIS_W],
                      axis_y[p*AXIS_W +: AXIS_W],
                      axis_x[p*AXIS_W +: AXIS_W]};
    apad_port #(.MAX_SEQ(MAX_SEQ), .LAT_GUARD(LAT_GUARD)) u_port (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(wr_stb[p]),
      .wr_data(wr_data[p*PORT_W +: PORT_W]),
      .wr_mask(wr_mask[p*PORT_W +: PORT_W]),
      .rd_stb(rd_stb[p]),
      .rd_data(rd_p),
      .btn_n(btn_n[p*BTN_W +: BTN_W]),
      .axis_ld(axis_ld[p]),
      .axes_in(axes_in)
    );
    assign rd_data[p*PORT_W +: PORT_W] = rd_p;
  end
endmodule

// File: rtl/apad_responder_chk.sv
`timescale 1ns/1ps
module apad_responder_chk
  import apad_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_PORTS-1:0]        wr_stb,
  input logic [NUM_PORTS*PORT_W-1:0] wr_data,
  input logic [NUM_PORTS*PORT_W-1:0] wr_mask,
  input logic [NUM_PORTS-1:0]        rd_stb,
  input logic [NUM_PORTS*PORT_W-1:0] rd_data,
  input logic [NUM_PORTS*BTN_W-1:0]  btn_n
);
  logic unused_chk_bits;
  assign unused_chk_bits = ^{wr_data, wr_mask, btn_n};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    localparam int B = p * PORT_W;

    // R2
    th_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb[p] && !wr_mask[B+TH_BIT]) |=> rd_data[B+5] == $past(rd_data[B+5]));

    // R2
    th_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb[p] && wr_mask[B+TH_BIT]) |=> rd_data[B+5] == $past(wr_data[B+TH_BIT]));

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb[p] && rd_data[B+5] && wr_mask[B+TH_BIT] && !wr_data[B+TH_BIT])
      |=> (rd_data[B+3 -: 4] == ~btn_n[p*BTN_W+7 -: 4]) && !rd_data[B+4]);

    // R7
    read_keeps_th_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb[p] && !wr_stb[p]) |=> $stable(rd_data[B+5]));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb[p] && !wr_stb[p]) |=> $stable(rd_data[B+5 -: 2]) && rd_data[B+6]);
  end
endmodule

bind apad_responder apad_responder_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
  .wr_mask(wr_mask), .rd_stb(rd_stb), .rd_data(rd_data), .btn_n(btn_n)
);

// File: tb/apad_responder_bench.sv
`timescale 1ns/1ps
module apad_responder_bench;
  localparam int NP = 2;

  logic            clk;
  logic            rst_n;
  logic [NP-1:0]   wr_stb, rd_stb, axis_ld;
  logic [NP*7-1:0] wr_data, wr_mask, rd_data;
  logic [NP*8-1:0] btn_n, axis_x, axis_y, axis_z;

  apad_responder #(.NUM_PORTS(NP)) u_apad_responder (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_stb(rd_stb), .rd_data(rd_data), .btn_n(btn_n),
    .axis_ld(axis_ld), .axis_x(axis_x), .axis_y(axis_y), .axis_z(axis_z)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [6:0] m_state [NP];
  int         m_cnt   [NP];
  int         m_lat   [NP];
  logic [7:0] m_ax    [NP][3];

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      report_end();
    end
  end

  function automatic logic [6:0] exp_read(int p);
    int idx, grp;
    logic [7:0] word;
    logic [3:0] nib;
    idx = m_cnt[p] >> 2;
    grp = idx >> 1;
    if (grp == 0)      word = ~btn_n[p*8 +: 8];
    else if (grp <= 3) word = m_ax[p][grp-1];
    else               word = 8'h00;
    nib = idx[0] ? word[3:0] : word[7:4];
    return {1'b1, m_state[p][6], idx[0], nib};
  endfunction

  task automatic chk(logic [6:0] act, logic [6:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic do_read(int p, string tag);
    @(negedge clk);
    rd_stb[p] = 1'b1;
    #5;
    chk(rd_data[p*7 +: 7], exp_read(p), tag);
    @(posedge clk);
    #1 rd_stb[p] = 1'b0;
    m_cnt[p] = (m_cnt[p] & ~7) | ((m_cnt[p] + 1) & 7);
    m_lat[p]++;
  endtask

  task automatic do_write(int p, logic [6:0] d, logic [6:0] m);
    logic [6:0] nxt;
    @(negedge clk);
    wr_stb[p] = 1'b1;
    wr_data[p*7 +: 7] = d;
    wr_mask[p*7 +: 7] = m;
    @(posedge clk);
    #1 wr_stb[p] = 1'b0;
    nxt = (m_state[p] & ~m) | (d & m);
    if (m_state[p][6] && !nxt[6]) begin
      m_cnt[p] = 0;
      m_lat[p] = 0;
    end else if (m_lat[p] > 2) begin
      m_cnt[p] = (m_cnt[p] & ~7) + 8;
      if (m_cnt[p] > 32) m_cnt[p] = 32;
    end
    m_state[p] = nxt;
  endtask

  task automatic do_load(int p, logic [7:0] x, logic [7:0] y, logic [7:0] z);
    @(negedge clk);
    axis_ld[p] = 1'b1;
    axis_x[p*8 +: 8] = x;
    axis_y[p*8 +: 8] = y;
    axis_z[p*8 +: 8] = z;
    @(posedge clk);
    #1 axis_ld[p] = 1'b0;
    m_ax[p][0] = x;
    m_ax[p][1] = y;
    m_ax[p][2] = z;
  endtask

  // Restart, then six sequences of eight reads; the last two sit at the saturated counter.
  task automatic sweep(int p, string tag);
    do_write(p, 7'h40, 7'h40);
    do_write(p, 7'h00, 7'h40);
    for (int s = 0; s < 6; s++) begin
      for (int r = 0; r < 8; r++) do_read(p, tag);
      do_write(p, 7'h40, 7'h40);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    wr_stb = '0; rd_stb = '0; axis_ld = '0;
    wr_data = '0; wr_mask = '0;
    btn_n = 16'h5AC3;
    axis_x = '0; axis_y = '0; axis_z = '0;
    for (int p = 0; p < NP; p++) begin
      m_state[p] = 7'h40; m_cnt[p] = 0; m_lat[p] = 0;
      for (int a = 0; a < 3; a++) m_ax[p][a] = 8'd128;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R10: reset state seen on both ports
    #3;
    chk(rd_data[6:0],  7'h60 | {3'b0, ~btn_n[7:4]},  "R1 reset port0");
    chk(rd_data[13:7], 7'h60 | {3'b0, ~btn_n[15:12]}, "R1 reset port1");

    // R11 R8 R6: centred axes, full stream
    sweep(0, "R11 R8 R6 centred sweep p0");

    // R9 R11 R8 R5: loaded axes and new button patterns on both ports
    btn_n = 16'h3CA5;
    do_load(0, 8'h1F, 8'hE2, 8'h7B);
    do_load(1, 8'hC4, 8'h09, 8'hF6);
    sweep(0, "R9 R8 R5 loaded sweep p0");
    sweep(1, "R9 R8 R5 loaded sweep p1");

    // R12: port1 mid-sequence while port0 runs a full sweep
    do_write(1, 7'h40, 7'h40);
    do_write(1, 7'h00, 7'h40);
    do_read(1, "R12 p1 before");
    do_read(1, "R12 p1 before");
    btn_n[7:0] = 8'h00;
    sweep(0, "R12 R9 sweep p0 all pressed");
    do_read(1, "R12 p1 after");
    do_read(1, "R12 p1 after");

    // R4: early write after two reads does not advance
    do_write(0, 7'h40, 7'h40);
    do_write(0, 7'h00, 7'h40);
    do_read(0, "R3 restart");
    do_read(0, "R4 guard");
    do_write(0, 7'h00, 7'h00);
    do_read(0, "R4 no advance");
    // R5: third read lifts the guard, next write moves to sequence 1
    do_write(0, 7'h00, 7'h00);
    do_read(0, "R5 advanced");
    do_read(0, "R7 cycle step");

    // R2: writes with the select bit masked off keep the line low and do not restart
    do_write(0, 7'h7F, 7'h3F);
    do_read(0, "R2 masked write");
    do_write(0, 7'h40, 7'h00);
    do_read(0, "R2 empty mask");

    // R7: eight reads wrap within the same sequence
    for (int r = 0; r < 9; r++) do_read(0, "R7 wrap");

    // R3: rise then fall restarts from nibble 0
    do_write(0, 7'h40, 7'h40);
    do_write(0, 7'h00, 7'h40);
    do_read(0, "R3 restart again");

    repeat (2) @(negedge clk);
    report_end();
  end
endmodule